// File: doc/BRIEF.md
# Carrier Sense and Collision Generator

This block produces the carrier sense (`crs`) and collision (`col`) indications that a physical-layer device presents to the MAC over a media-independent interface. It does not look at the wire. It takes two activity flags, one for transmit and one for receive, that other logic supplies. It combines them with a set of operating-mode pins to form the two outputs. Both outputs are synchronous to the reference clock, and each is registered one clock after the activity flags are sampled.

Carrier sense depends on the mode. A half-duplex end station sees carrier while it transmits or receives. Repeater, full-duplex and loopback operation report carrier for receive activity only. Collision is raised in half duplex when both directions are active at once. At 10 Mb/s in half duplex, with heartbeat enabled, the block also drives a signal-quality-error pulse on `col` after every transmission. The pulse length is set by a cycle-count parameter: 25000 cycles of a 25 MHz clock gives about 1 ms. The mode pins are captured while reset is held and stay frozen until the next reset.

Top module: `mii_crs_col`

## Requirements
- R1: With repeater, full duplex and loopback all 0, `crs` is 1 in the cycle after any clock edge that samples `txActive` or `rxActive` high.
- R2: With repeater, full duplex or loopback set, `crs` follows only `rxActive`, one cycle later. Transmit activity alone leaves `crs` at 0.
- R3: With full duplex 0, at either speed, `col` is 1 in the cycle after an edge that samples both `txActive` and `rxActive` high.
- R4: With full duplex 1, `col` stays 0 at all times, and no heartbeat pulse is produced after a transmission.
- R5: With speed10=1, full duplex 0 and heartbeat enabled, the first edge that samples `txActive` low after it was high starts a pulse on `col`. The pulse lasts exactly HB_CYCLES cycles, starting at that edge.
- R6: No heartbeat pulse appears when speed10=0 or when heartbeat is disabled.
- R7: An edge that samples `txActive` high while a heartbeat pulse is running ends the pulse. `col` is 0 after that edge unless `rxActive` was also high.
- R8: The mode pins are taken from the last clock edge at which `rstN` is low. Changes on those pins after reset is released have no effect.
- R9: While `rstN` is low (synchronous, active low), `crs` and `col` are 0 after each clock edge, and no heartbeat is pending.
- R10: When both activity flags are sampled low, `crs` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Synchronous active-low reset; mode pins are captured while it is low |
| txActive | input | 1 | Transmit activity flag |
| rxActive | input | 1 | Receive activity flag |
| cfgRepeater | input | 1 | 1 = repeater operation, 0 = end station |
| cfgFullDuplex | input | 1 | 1 = full duplex |
| cfgLoopback | input | 1 | 1 = loopback operation |
| cfgSpeed10 | input | 1 | 1 = 10 Mb/s, 0 = 100 Mb/s |
| cfgHeartbeatEn | input | 1 | 1 = heartbeat pulse enabled |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision, including the heartbeat pulse |

## Verification
The case that is hardest to reach from the ports is a heartbeat pulse interrupted by a new transmission. The stimulus first configures 10 Mb/s half duplex with heartbeat enabled through a reset. It then ends a transmission and raises `txActive` again a few cycles into the pulse. The bench checks that `col` drops on the following cycle and that the next transmit end starts a fresh, full-length pulse. To keep the pulse window short enough to count cycle by cycle, the bench sets the pulse length parameter to a small value. It then checks both the last pulse cycle and the first cycle after it.

// File: rtl/crscol_pkg.sv
package crscol_pkg;

  typedef struct packed {
    logic repeater;
    logic fullDuplex;
    logic loopback;
    logic speed10;
    logic hbEnable;
  } modeCfg_t;

  typedef struct packed {
    logic crsNext;
    logic colNext;
    logic hbLoad;
    logic hbClear;
  } ctrlStrobes_t;

endpackage

// File: rtl/crscol_ctrl.sv
module crscol_ctrl
  import crscol_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  modeCfg_t     cfgIn,
  input  logic         txActive,
  input  logic         rxActive,
  output modeCfg_t     mode,
  output ctrlStrobes_t strb
);

  modeCfg_t modeQ;
  logic     txPrev;
  logic     rxOnly;
  logic     hbAllowed;

  // Mode is captured on every edge while reset is held, then frozen.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= cfgIn;
      txPrev <= 1'b0;
    end else begin
      txPrev <= txActive;
    end
  end

  always_comb begin
    rxOnly       = modeQ.repeater | modeQ.fullDuplex | modeQ.loopback;
    hbAllowed    = modeQ.speed10 & ~modeQ.fullDuplex & modeQ.hbEnable;
    strb.crsNext = rxActive | (txActive & ~rxOnly);
    strb.colNext = ~modeQ.fullDuplex & txActive & rxActive;
    strb.hbLoad  = hbAllowed & txPrev & ~txActive;
    strb.hbClear = txActive;
  end

  assign mode = modeQ;

endmodule

// File: rtl/crscol_dp.sv
module crscol_dp
  import crscol_pkg::*;
#(
  parameter int HB_CYCLES = 25000
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  output logic         crsOut,
  output logic         colOut
);

  localparam int CW = $clog2(HB_CYCLES + 1);

  logic [CW-1:0] hbCount;
  logic          crsQ;
  logic          colQ;
  logic          hbActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hbCount <= '0;
      crsQ    <= 1'b0;
      colQ    <= 1'b0;
    end else begin
      crsQ <= strb.crsNext;
      colQ <= strb.colNext;
      if (strb.hbLoad)
        hbCount <= CW'(HB_CYCLES);
      else if (strb.hbClear)
        hbCount <= '0;
      else if (hbCount != '0)
        hbCount <= hbCount - 1'b1;
    end
  end

  assign hbActive = (hbCount != '0);
  assign crsOut   = crsQ;
  assign colOut   = colQ | hbActive;

endmodule

// File: rtl/mii_crs_col.sv
module mii_crs_col
  import crscol_pkg::*;
#(
  parameter int HB_CYCLES = 25000
) (
  input  logic clk,
  input  logic rstN,
  input  logic txActive,
  input  logic rxActive,
  input  logic cfgRepeater,
  input  logic cfgFullDuplex,
  input  logic cfgLoopback,
  input  logic cfgSpeed10,
  input  logic cfgHeartbeatEn,
  output logic crs,
  output logic col
);

  modeCfg_t     cfgIn;
  modeCfg_t     mode;
  ctrlStrobes_t strb;

  assign cfgIn = '{repeater:   cfgRepeater,
                   fullDuplex: cfgFullDuplex,
                   loopback:   cfgLoopback,
                   speed10:    cfgSpeed10,
                   hbEnable:   cfgHeartbeatEn};

  crscol_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgIn    (cfgIn),
    .txActive (txActive),
    .rxActive (rxActive),
    .mode     (mode),
    .strb     (strb)
  );

  crscol_dp #(.HB_CYCLES(HB_CYCLES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .crsOut (crs),
    .colOut (col)
  );

endmodule

// File: rtl/crscol_checker.sv
module crscol_checker
  import crscol_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     txActive,
  input logic     rxActive,
  input logic     crs,
  input logic     col,
  input modeCfg_t mode
);

  logic armed;
  logic rxOnlyMode;

  always_ff @(posedge clk) armed <= rstN;

  assign rxOnlyMode = mode.repeater | mode.fullDuplex | mode.loopback;

  a_r1_node_crs: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !rxOnlyMode && (txActive || rxActive)) |=> crs);

  a_r2_rx_only_crs: assert property (@(posedge clk) disable iff (!rstN)
    (armed && rxOnlyMode && !rxActive) |=> !crs);

  a_r3_collision: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !mode.fullDuplex && txActive && rxActive) |=> col);

  a_r4_fdx_no_col: assert property (@(posedge clk) disable iff (!rstN)
    (armed && mode.fullDuplex) |=> !col);

  a_r7_hb_cut: assert property (@(posedge clk) disable iff (!rstN)
    (armed && txActive && !rxActive) |=> !col);

  a_r10_idle_crs: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !txActive && !rxActive) |=> !crs);

  a_r9_reset_quiet: assert property (@(posedge clk)
    (armed === 1'b0 && rstN === 1'b0) |=> (!crs && !col));

endmodule

bind mii_crs_col crscol_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .txActive (txActive),
  .rxActive (rxActive),
  .crs      (crs),
  .col      (col),
  .mode     (mode)
);

// File: tb/mii_crs_col_test.sv
module mii_crs_col_test;

  localparam int HB = 20;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txActive = 1'b0, rxActive = 1'b0;
  logic cfgRepeater = 1'b0, cfgFullDuplex = 1'b0, cfgLoopback = 1'b0;
  logic cfgSpeed10 = 1'b0, cfgHeartbeatEn = 1'b0;
  logic crs, col;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mii_crs_col #(.HB_CYCLES(HB)) uut (
    .clk(clk), .rstN(rstN), .txActive(txActive), .rxActive(rxActive),
    .cfgRepeater(cfgRepeater), .cfgFullDuplex(cfgFullDuplex),
    .cfgLoopback(cfgLoopback), .cfgSpeed10(cfgSpeed10),
    .cfgHeartbeatEn(cfgHeartbeatEn), .crs(crs), .col(col)
  );

  // {rep, fdx, lb, spd10, hbEn, tx, rx, expCrs, expCol}
  localparam logic [8:0] VEC [NV] = '{
    9'b00000_10_10, 9'b00000_01_10, 9'b00000_11_11, 9'b00000_00_00,
    9'b10000_10_00, 9'b10000_11_11, 9'b01000_10_00, 9'b01000_11_10,
    9'b00100_10_00, 9'b00100_01_10, 9'b00010_11_11, 9'b10000_01_10
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic [4:0] cfg);
    @(negedge clk);
    rstN = 1'b0; txActive = 1'b0; rxActive = 1'b0;
    {cfgRepeater, cfgFullDuplex, cfgLoopback, cfgSpeed10, cfgHeartbeatEn} = cfg;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive(input logic tx, input logic rx);
    txActive = tx; rxActive = rx;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: reset holds outputs low even with activity present
    @(negedge clk);
    txActive = 1'b1; rxActive = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 crs in reset", crs, 1'b0);
    check("R9 col in reset", col, 1'b0);

    // Vector table: R1 R2 R3 R4 R10
    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      v = VEC[i];
      doReset(v[8:4]);
      drive(v[3], v[2]);
      check((v[8] | v[7] | v[6]) ? "R2 crs" : (v[3] | v[2]) ? "R1 crs" : "R10 crs",
            crs, v[1]);
      check(v[7] ? "R4 col" : "R3 col", col, v[0]);
    end

    // R5: heartbeat pulse length
    doReset(5'b00011);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b0);
    txActive = 1'b0;
    @(negedge clk);
    check("R5 first pulse cycle", col, 1'b1);
    check("R10 crs after tx end", crs, 1'b0);
    for (int k = 2; k <= HB; k++) @(negedge clk);
    check("R5 last pulse cycle", col, 1'b1);
    @(negedge clk);
    check("R5 pulse ended", col, 1'b0);

    // R7: pulse cut short by new transmission, then a fresh pulse
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    check("R7 pulse started", col, 1'b1);
    for (int k = 0; k < 4; k++) @(negedge clk);
    drive(1'b1, 1'b0);
    check("R7 col cut", col, 1'b0);
    check("R1 crs on retransmit", crs, 1'b1);
    drive(1'b0, 1'b0);
    check("R7 new pulse", col, 1'b1);
    for (int k = 1; k < HB; k++) @(negedge clk);
    check("R7 new pulse full length", col, 1'b1);
    @(negedge clk);
    check("R7 new pulse ends", col, 1'b0);

    // R4: full duplex gives no heartbeat
    doReset(5'b01011);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    check("R4 no heartbeat", col, 1'b0);
    drive(1'b0, 1'b0);
    check("R4 no heartbeat later", col, 1'b0);

    // R6: heartbeat disabled, and 100 Mb/s
    doReset(5'b00010);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    check("R6 hb disabled", col, 1'b0);
    doReset(5'b00001);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    check("R6 100M no hb", col, 1'b0);

    // R8: mode pins changed after reset release are ignored
    doReset(5'b00000);
    cfgRepeater = 1'b1; cfgFullDuplex = 1'b1; cfgLoopback = 1'b1;
    drive(1'b1, 1'b0);
    check("R8 crs keeps node mode", crs, 1'b1);
    drive(1'b1, 1'b1);
    check("R8 col keeps half duplex", col, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule